// File: doc/BRIEF.md
# Standby Power-Mode Controller

This block decides when a small microcontroller core may sleep and how deeply. Firmware raises a one-cycle sleep request with a depth bit. A light sleep only gates the core clock, and the main oscillator keeps running. A deep sleep also switches the main oscillator off. Any enabled interrupt request brings the core back.

Waking from light sleep gives the clock back on the next edge. Waking from deep sleep first turns the oscillator on again. It then holds the core clock gated while a settle counter, loaded from a configuration input, runs down to zero.

Two guards protect clock integrity:
- A deep request made while the core runs from the subsystem clock becomes a light sleep, so that clock source is never stopped.
- A request that arrives while a clock-source switch is still timing out is parked until the switch timer reaches zero. The request is then taken up.

The oscillator-enable and clock-gate outputs come straight from flops, and they move only when the mode changes.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (active), `osc_en` is 1 and `cpu_clk_en` is 1.
- R2: In active mode, a request with `req_deep`=0 and no pending interrupt and no switch in progress makes `mode` 2 (light) one cycle later, with `cpu_clk_en`=0 and `osc_en`=1.
- R3: In active mode, a request with `req_deep`=1 while `sub_sel`=0, with no pending interrupt and no switch in progress, makes `mode` 3 (deep) one cycle later, with `osc_en`=0 and `cpu_clk_en`=0.
- R4: A deep request while `sub_sel`=1 enters light mode (2), never deep mode, and `osc_en` stays 1.
- R5: In light mode, `irq_pend`=1 returns `mode` to 0 with `cpu_clk_en`=1 one cycle later.
- R6: In deep mode, `irq_pend`=1 moves `mode` to 4 (settling) one cycle later, with `osc_en`=1 and `cpu_clk_en`=0. It stays there for `stab_cfg`+1 cycles and then returns to 0 with `cpu_clk_en`=1.
- R7: A request made while `irq_pend`=1 is cancelled, and `mode` stays 0.
- R8: A request made while the switch timer is busy moves `mode` to 1 (parked) with `cpu_clk_en`=1. `sw_start` loads `sw_len`, and the timer counts down once per cycle. The parked request enters its standby mode on the cycle after the timer reads zero.
- R9: In parked mode, `irq_pend`=1 returns `mode` to 0.
- R10: `req_valid` has no effect outside active mode. For example, a deep request during light mode leaves `mode` at 2 and `osc_en` at 1.
- R11: `osc_en` and `cpu_clk_en` change only in a cycle in which `mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle standby request |
| req_deep | input | 1 | Request depth: 1 deep, 0 light |
| irq_pend | input | 1 | An enabled interrupt request is pending |
| sub_sel | input | 1 | Core clock currently from the subsystem source |
| sw_start | input | 1 | A clock-source switch starts this cycle |
| sw_len | input | SW_W | Switch settling time in cycles |
| stab_cfg | input | STAB_W | Oscillator settle count after deep wake |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | Core clock gate enable (1 = running) |
| mode | output | 3 | Current mode: 0 active, 1 parked, 2 light, 3 deep, 4 settling |

## Verification
Every mode transition appears one edge after the input that causes it. The bench therefore drives just after an edge and samples one time unit after the next edge.

Deep wake is the long case. Settling begins one edge after the interrupt and lasts `stab_cfg`+1 edges. The bench checks the settling code on each of those edges and the active code on the edge after.

For a parked request, the bench counts `sw_len`+1 edges from `sw_start` before it expects the standby code, and it checks the parked code on every edge before that.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        M_ACTIVE = 3'd0,
        M_PARKED = 3'd1,
        M_LIGHT  = 3'd2,
        M_DEEP   = 3'd3,
        M_SETTLE = 3'd4
    } mode_t;

    typedef struct packed {
        logic osc_on;
        logic core_on;
    } gate_t;

    function automatic gate_t gates_for(mode_t m);
        gate_t g;
        g.osc_on  = (m != M_DEEP);
        g.core_on = (m == M_ACTIVE) || (m == M_PARKED);
        return g;
    endfunction

    function automatic mode_t sleep_target(logic deep, logic on_sub);
        return (deep && !on_sub) ? M_DEEP : M_LIGHT;
    endfunction

endpackage

// File: rtl/stby_swtimer.sv
module stby_swtimer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         busy
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0) || start;
endmodule

// File: rtl/stby_settle.sv
module stby_settle #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         run,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= init;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  req_deep,
    input  logic  irq_pend,
    input  logic  sub_sel,
    input  logic  sw_busy,
    input  logic  settle_done,
    output logic  settle_load,
    output mode_t mode_q,
    output gate_t gate_q
);
    mode_t nxt;
    logic  park_deep_q;

    always_comb begin
        nxt = mode_q;
        unique case (mode_q)
            M_ACTIVE: if (req_valid && !irq_pend)
                          nxt = sw_busy ? M_PARKED : sleep_target(req_deep, sub_sel);
            M_PARKED: if (irq_pend)      nxt = M_ACTIVE;
                      else if (!sw_busy) nxt = sleep_target(park_deep_q, sub_sel);
            M_LIGHT:  if (irq_pend)      nxt = M_ACTIVE;
            M_DEEP:   if (irq_pend)      nxt = M_SETTLE;
            M_SETTLE: if (settle_done)   nxt = M_ACTIVE;
            default:                     nxt = M_ACTIVE;
        endcase
    end

    assign settle_load = (mode_q == M_DEEP) && (nxt == M_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= M_ACTIVE;
            gate_q      <= gates_for(M_ACTIVE);
            park_deep_q <= 1'b0;
        end else begin
            mode_q <= nxt;
            if (nxt != mode_q) gate_q <= gates_for(nxt);
            if (mode_q == M_ACTIVE && req_valid) park_deep_q <= req_deep;
        end
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int SW_W   = 8,
    parameter int STAB_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_deep,
    input  logic              irq_pend,
    input  logic              sub_sel,
    input  logic              sw_start,
    input  logic [SW_W-1:0]   sw_len,
    input  logic [STAB_W-1:0] stab_cfg,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic [2:0]        mode
);
    logic  sw_busy, settle_done, settle_load;
    mode_t mode_q;
    gate_t gate_q;

    stby_swtimer #(.W(SW_W)) u_sw (
        .clk(clk), .rst(rst), .start(sw_start), .len(sw_len), .busy(sw_busy)
    );

    stby_settle #(.W(STAB_W)) u_settle (
        .clk(clk), .rst(rst), .load(settle_load), .init(stab_cfg),
        .run(gate_q.osc_on && mode_q == M_SETTLE), .done(settle_done)
    );

    stby_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_deep(req_deep),
        .irq_pend(irq_pend), .sub_sel(sub_sel), .sw_busy(sw_busy),
        .settle_done(settle_done), .settle_load(settle_load),
        .mode_q(mode_q), .gate_q(gate_q)
    );

    assign osc_en     = gate_q.osc_on;
    assign cpu_clk_en = gate_q.core_on;
    assign mode       = mode_q;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       irq_pend,
    input logic       sub_sel,
    input logic       osc_en,
    input logic       cpu_clk_en,
    input logic [2:0] mode
);
    logic seen;
    always_ff @(posedge clk) seen <= rst ? 1'b0 : 1'b1;

    p_deep_osc_off_r3: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd3 |-> !osc_en && !cpu_clk_en);

    p_light_core_off_r2: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd2 |-> osc_en && !cpu_clk_en);

    p_sub_never_deep_r4: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd0 && req_valid && sub_sel |=> mode != 3'd3);

    p_light_wake_r5: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd2 && irq_pend |=> mode == 3'd0 && cpu_clk_en);

    p_settle_gated_r6: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd4 |-> osc_en && !cpu_clk_en);

    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd0 && req_valid && irq_pend |=> mode == 3'd0);

    p_parked_wake_r9: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd1 && irq_pend |=> mode == 3'd0);

    p_gates_follow_mode_r11: assert property (@(posedge clk) disable iff (rst || !seen)
        $stable(mode) |-> $stable(osc_en) && $stable(cpu_clk_en));
endmodule

bind stby_ctrl stby_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .irq_pend(irq_pend),
    .sub_sel(sub_sel), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .mode(mode)
);

// File: tb/stby_ctrl_test.sv
`timescale 1ns/1ps
module stby_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_deep, irq_pend, sub_sel, sw_start;
    logic [7:0]  sw_len;
    logic [15:0] stab_cfg;
    logic        osc_en, cpu_clk_en;
    logic [2:0]  mode;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    stby_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_deep(req_deep),
        .irq_pend(irq_pend), .sub_sel(sub_sel), .sw_start(sw_start),
        .sw_len(sw_len), .stab_cfg(stab_cfg), .osc_en(osc_en),
        .cpu_clk_en(cpu_clk_en), .mode(mode)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag, logic [2:0] m, logic o, logic c);
        chk({tag, " mode"}, mode, m);
        chk({tag, " osc_en"}, {2'b0, osc_en}, {2'b0, o});
        chk({tag, " cpu_clk_en"}, {2'b0, cpu_clk_en}, {2'b0, c});
    endtask

    task automatic request(logic deep);
        req_valid = 1'b1; req_deep = deep;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wake();
        irq_pend = 1'b1;
        tick();
        irq_pend = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 0; req_deep = 0; irq_pend = 0; sub_sel = 0;
        sw_start = 0; sw_len = 0; stab_cfg = 0;
        tick(); tick();
        rst = 1'b0;
        chk_all("R1 reset", 3'd0, 1'b1, 1'b1);
        tick();
        chk_all("R1 after release", 3'd0, 1'b1, 1'b1);
    endtask

    task automatic t_light();
        request(1'b0);
        chk_all("R2 light entry", 3'd2, 1'b1, 1'b0);
        request(1'b1);
        chk_all("R10 request ignored in light", 3'd2, 1'b1, 1'b0);
        tick();
        chk_all("R11 gates hold in light", 3'd2, 1'b1, 1'b0);
        wake();
        chk_all("R5 light wake", 3'd0, 1'b1, 1'b1);
    endtask

    task automatic t_deep(int n);
        stab_cfg = 16'(n);
        request(1'b1);
        chk_all("R3 deep entry", 3'd3, 1'b0, 1'b0);
        tick();
        chk("R3 deep holds", mode, 3'd3);
        wake();
        stab_cfg = 16'hFFFF;
        chk_all("R6 settle start", 3'd4, 1'b1, 1'b0);
        for (int k = 0; k < n; k++) begin
            tick();
            chk("R6 still settling", mode, 3'd4);
        end
        tick();
        chk_all("R6 settle done", 3'd0, 1'b1, 1'b1);
    endtask

    task automatic t_sub();
        sub_sel = 1'b1;
        request(1'b1);
        chk_all("R4 deep on subsystem clock", 3'd2, 1'b1, 1'b0);
        wake();
        chk("R4 wake", mode, 3'd0);
        sub_sel = 1'b0;
    endtask

    task automatic t_cancel();
        irq_pend = 1'b1;
        request(1'b0);
        chk_all("R7 light cancelled", 3'd0, 1'b1, 1'b1);
        request(1'b1);
        chk_all("R7 deep cancelled", 3'd0, 1'b1, 1'b1);
        irq_pend = 1'b0;
    endtask

    task automatic t_switch(logic deep, int len);
        sw_len = 8'(len); sw_start = 1'b1;
        tick();
        sw_start = 1'b0;
        request(deep);
        chk_all("R8 parked", 3'd1, 1'b1, 1'b1);
        for (int k = 1; k < len; k++) begin
            tick();
            chk("R8 still parked", mode, 3'd1);
        end
        tick();
        if (deep) chk_all("R8 deep after switch", 3'd3, 1'b0, 1'b0);
        else      chk_all("R8 light after switch", 3'd2, 1'b1, 1'b0);
        stab_cfg = 0;
        wake();
        if (deep) tick();
        chk("R8 back to active", mode, 3'd0);
    endtask

    task automatic t_park_irq();
        sw_len = 8'd6; sw_start = 1'b1;
        tick();
        sw_start = 1'b0;
        request(1'b1);
        chk("R9 parked", mode, 3'd1);
        wake();
        chk_all("R9 parked wake", 3'd0, 1'b1, 1'b1);
        for (int k = 0; k < 8; k++) tick();
        chk("R9 stays active", mode, 3'd0);
    endtask

    initial begin
        t_reset();
        t_light();
        t_deep(5);
        t_deep(0);
        t_sub();
        t_cancel();
        t_switch(1'b0, 3);
        t_switch(1'b1, 4);
        t_park_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule